// File: doc/BRIEF.md
# Two-Pass 8x8 Fast Integer Forward DCT

This block takes an 8x8 tile of signed 16-bit samples and returns its 2-D forward DCT coefficients in the scaled domain of the fast integer factorisation. Each input beat carries one sample row of eight lanes. As each row is accepted, it runs through an eight-point butterfly datapath. The result is written into an internal 8x8 buffer. After the eighth row, the same datapath reads the buffer one column at a time and writes each transformed column back into that column. This does the transpose in place. The block then streams out eight coefficient rows.

All arithmetic is 16-bit two's complement and wraps on overflow. No rounding or descaling is applied between the passes or at the end. The per-coefficient scale factors of the fast algorithm are left to a downstream quantizer. Level shifting, quantization and entropy coding are not part of this block.

Top module: `fdct2d`

## Requirements
- R1: When reset is released, `outValid`, `inReady` and `frameErr` are low. `inReady` rises one clock later.
- R2: `inReady` is high for exactly eight accepted beats per tile. It then stays low until the beat that carries `outLast` has handshaken. `inReady` and `outValid` are never high together, and input offered while busy is not taken.
- R3: Each pass applies the eight-point transform to lanes x0..x7 in 16-bit wrapping arithmetic. The sums are s07=x0+x7, s16=x1+x6, s25=x2+x5, s34=x3+x4, and the differences are d07=x0-x7, d16=x1-x6, d25=x2-x5, d34=x3-x4. Let e0=s07+s34, e1=s16+s25, e2=s16-s25, e3=s07-s34. Then y0=e0+e1, y4=e0-e1, q=M(e2+e3,23168), y2=e3+q, y6=e3-q.
- R4: The odd outputs use a=d34+d25, b=d25+d16 and c=d16+d07, with r=M(a-c,12544), u=M(a,17792)+r, v=M(c,9984)+c+r, w=M(b,23168), p=d07+w and n=d07-w. They are y5=n+u, y3=n-u, y1=p+v and y7=p-v.
- R5: M(a,k) is the signed 32-bit product a*k arithmetically shifted right by 15 (floor), keeping the low 16 bits.
- R6: Coefficient (k,c) equals the column transform, applied to column c of the row-pass result, evaluated at position k. Output beat k carries vertical frequency k, and lane c (bits [16c+15:16c]) carries horizontal frequency c. The same lane mapping applies to the input, where lane c is sample column c.
- R7: Full-scale inputs wrap in 16 bits inside both passes rather than saturating.
- R8: `outLast` is high only on the eighth coefficient row, and `outValid` drops after that beat handshakes.
- R9: While `outValid` is high and `outReady` is low, `outValid`, `outData` and `outLast` hold their values.
- R10: `frameErr` pulses high for one cycle after any accepted beat whose `inLast` differs from "this is the eighth beat". Framing still follows the beat count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Input row valid |
| inReady | output | 1 | Block can accept a row |
| inData | input | 128 | Eight signed 16-bit samples, lane c at [16c+15:16c] |
| inLast | input | 1 | Producer marks the eighth row |
| outValid | output | 1 | Coefficient row valid |
| outReady | input | 1 | Consumer accepts the row |
| outData | output | 128 | Eight signed 16-bit coefficients, lane c at [16c+15:16c] |
| outLast | output | 1 | Eighth coefficient row |
| frameErr | output | 1 | One-cycle pulse on an `inLast` mismatch |

## Verification
The bench sends full-scale alternating tiles that force wraparound in both passes. A saturating or widened datapath would return different coefficients there. Negative-heavy random tiles catch a multiply that rounds toward zero instead of flooring. Single-impulse and DC tiles expose a swapped lane or transposed output order as misplaced coefficients. Random output backpressure, together with input offered during the busy phase, shows whether a design drops or changes held rows or swallows the next tile's first row early. A tile with `inLast` on the wrong beat checks that the error pulse fires on both the early and the missing marker while framing stays intact.

// File: rtl/fdct2d_pkg.sv
package fdct2d_pkg;
  localparam int W = 16;
  localparam int N = 8;
  localparam int IDX_W = $clog2(N);

  typedef logic [N-1:0][W-1:0] row_t;

  typedef struct packed {
    logic             loadRow;
    logic             colStep;
    logic [IDX_W-1:0] idx;
  } ctrl_t;

  localparam logic signed [W-1:0] K382 = 16'sd12544;
  localparam logic signed [W-1:0] K541 = 16'sd17792;
  localparam logic signed [W-1:0] K707 = 16'sd23168;
  localparam logic signed [W-1:0] K306 = 16'sd9984;

  // fractional multiply: floor(a*k / 2^15), low W bits
  function automatic logic signed [W-1:0] fmul(input logic signed [W-1:0] a,
                                               input logic signed [W-1:0] k);
    logic signed [2*W-1:0] prod;
    prod = a * k;
    return prod[2*W-2:W-1];
  endfunction

  function automatic row_t fdct8(input row_t v);
    logic signed [W-1:0] x [N];
    logic signed [W-1:0] s07, s16, s25, s34, d07, d16, d25, d34;
    logic signed [W-1:0] e0, e1, e2, e3, q, a, b, c, r, u, vv, w, p, n;
    row_t y;
    for (int j = 0; j < N; j++) x[j] = v[j];
    s07 = x[0] + x[7]; d07 = x[0] - x[7];
    s16 = x[1] + x[6]; d16 = x[1] - x[6];
    s25 = x[2] + x[5]; d25 = x[2] - x[5];
    s34 = x[3] + x[4]; d34 = x[3] - x[4];
    e0 = s07 + s34; e3 = s07 - s34;
    e1 = s16 + s25; e2 = s16 - s25;
    q = fmul(e2 + e3, K707);
    y[0] = e0 + e1;
    y[4] = e0 - e1;
    y[2] = e3 + q;
    y[6] = e3 - q;
    a = d34 + d25;
    b = d25 + d16;
    c = d16 + d07;
    r = fmul(a - c, K382);
    u = fmul(a, K541) + r;
    vv = fmul(c, K306) + (c + r);
    w = fmul(b, K707);
    p = d07 + w;
    n = d07 - w;
    y[5] = n + u;
    y[3] = n - u;
    y[1] = p + vv;
    y[7] = p - vv;
    return y;
  endfunction
endpackage

// File: rtl/fdct2d_ctrl.sv
module fdct2d_ctrl
  import fdct2d_pkg::*;
(
  input  logic  clk,
  input  logic  rstN,
  input  logic  inValid,
  input  logic  inLast,
  input  logic  outReady,
  output logic  inReady,
  output logic  outValid,
  output logic  outLast,
  output logic  frameErr,
  output ctrl_t ctrl
);
  typedef enum logic [1:0] {IDLE, LOAD_ROWS, COL_PASS, EMIT} state_t;

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N - 1);

  state_t state;
  logic [IDX_W-1:0] cnt;
  logic accept;

  assign inReady  = (state == LOAD_ROWS);
  assign outValid = (state == EMIT);
  assign outLast  = outValid && (cnt == LAST_IDX);
  assign accept   = inReady && inValid;

  always_comb begin
    ctrl.loadRow = accept;
    ctrl.colStep = (state == COL_PASS);
    ctrl.idx     = cnt;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= IDLE;
      cnt      <= '0;
      frameErr <= 1'b0;
    end else begin
      frameErr <= accept && (inLast != (cnt == LAST_IDX));
      case (state)
        IDLE: begin
          cnt   <= '0;
          state <= LOAD_ROWS;
        end
        LOAD_ROWS: if (inValid) begin
          cnt <= cnt + 1'b1;
          if (cnt == LAST_IDX) state <= COL_PASS;
        end
        COL_PASS: begin
          cnt <= cnt + 1'b1;
          if (cnt == LAST_IDX) state <= EMIT;
        end
        EMIT: if (outReady) begin
          cnt <= cnt + 1'b1;
          if (cnt == LAST_IDX) state <= IDLE;
        end
        default: state <= IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fdct2d_dp.sv
module fdct2d_dp
  import fdct2d_pkg::*;
(
  input  logic  clk,
  input  ctrl_t ctrl,
  input  row_t  inData,
  output row_t  outData
);
  logic [W-1:0] tile [N][N];
  row_t colVec, passIn, passOut;

  for (genvar g = 0; g < N; g++) begin : g_lane
    assign colVec[g]  = tile[g][ctrl.idx];
    assign outData[g] = tile[ctrl.idx][g];
  end

  assign passIn  = ctrl.colStep ? colVec : inData;
  assign passOut = fdct8(passIn);

  always_ff @(posedge clk) begin
    if (ctrl.loadRow) begin
      for (int j = 0; j < N; j++) tile[ctrl.idx][j] <= passOut[j];
    end else if (ctrl.colStep) begin
      for (int j = 0; j < N; j++) tile[j][ctrl.idx] <= passOut[j];
    end
  end
endmodule

// File: rtl/fdct2d.sv
module fdct2d
  import fdct2d_pkg::*;
(
  input  logic           clk,
  input  logic           rstN,
  input  logic           inValid,
  output logic           inReady,
  input  logic [N*W-1:0] inData,
  input  logic           inLast,
  output logic           outValid,
  input  logic           outReady,
  output logic [N*W-1:0] outData,
  output logic           outLast,
  output logic           frameErr
);
  ctrl_t ctrl;
  row_t  outRow;

  fdct2d_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inLast(inLast),
    .outReady(outReady), .inReady(inReady), .outValid(outValid),
    .outLast(outLast), .frameErr(frameErr), .ctrl(ctrl)
  );

  fdct2d_dp u_dp (
    .clk(clk), .ctrl(ctrl), .inData(row_t'(inData)), .outData(outRow)
  );

  assign outData = outRow;
endmodule

// File: rtl/fdct2d_chk.sv
module fdct2d_chk
  import fdct2d_pkg::*;
(
  input logic           clk,
  input logic           rstN,
  input logic           inValid,
  input logic           inReady,
  input logic           outValid,
  input logic           outReady,
  input logic [N*W-1:0] outData,
  input logic           outLast,
  input logic           frameErr
);
  // R2
  busy_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(inReady && outValid));

  // R9
  out_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outData) && $stable(outLast)));

  // R8
  last_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    outLast |-> outValid);

  // R8
  end_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outReady && outLast) |=> !outValid);

  // R10
  err_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameErr |-> $past(inValid && inReady));

  // R10
  err_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameErr |=> !frameErr || $past(inValid && inReady));
endmodule

bind fdct2d fdct2d_chk u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
  .outValid(outValid), .outReady(outReady), .outData(outData),
  .outLast(outLast), .frameErr(frameErr)
);

// File: tb/fdct2d_tb.sv
module fdct2d_tb;
  typedef int vec8_t [8];
  typedef logic [127:0] bits_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic inLast = 1'b0;
  logic outReady = 1'b1;
  bits_t inData = '0;
  logic inReady, outValid, outLast, frameErr;
  bits_t outData;

  always #10 clk = ~clk;

  fdct2d u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .inData(inData), .inLast(inLast), .outValid(outValid),
    .outReady(outReady), .outData(outData), .outLast(outLast),
    .frameErr(frameErr)
  );

  int checks = 0;
  int fails = 0;
  bits_t expQ [$];
  int tileIn [8][8];
  bit stallMode = 1'b0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input bits_t act, input bits_t exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int wrap16(input int v);
    logic signed [15:0] t;
    t = v[15:0];
    return int'(t);
  endfunction

  function automatic int frac(input int a, input int k);
    return wrap16((a * k) >>> 15);
  endfunction

  // R3 R4 R5: one eight-point pass
  function automatic vec8_t pass8(input vec8_t x);
    vec8_t y;
    int sA, sB, sC, sD, dA, dB, dC, dD, ev0, ev1, ev2, ev3, qq;
    int oa, ob, oc, rr, uu, vv, ww, pp, nn;
    sA = wrap16(x[0] + x[7]); dA = wrap16(x[0] - x[7]);
    sB = wrap16(x[1] + x[6]); dB = wrap16(x[1] - x[6]);
    sC = wrap16(x[2] + x[5]); dC = wrap16(x[2] - x[5]);
    sD = wrap16(x[3] + x[4]); dD = wrap16(x[3] - x[4]);
    ev0 = wrap16(sA + sD); ev3 = wrap16(sA - sD);
    ev1 = wrap16(sB + sC); ev2 = wrap16(sB - sC);
    qq = frac(wrap16(ev2 + ev3), 23168);
    y[0] = wrap16(ev0 + ev1); y[4] = wrap16(ev0 - ev1);
    y[2] = wrap16(ev3 + qq);  y[6] = wrap16(ev3 - qq);
    oa = wrap16(dD + dC); ob = wrap16(dC + dB); oc = wrap16(dB + dA);
    rr = frac(wrap16(oa - oc), 12544);
    uu = wrap16(frac(oa, 17792) + rr);
    vv = wrap16(frac(oc, 9984) + wrap16(oc + rr));
    ww = frac(ob, 23168);
    pp = wrap16(dA + ww); nn = wrap16(dA - ww);
    y[5] = wrap16(nn + uu); y[3] = wrap16(nn - uu);
    y[1] = wrap16(pp + vv); y[7] = wrap16(pp - vv);
    return y;
  endfunction

  function automatic bits_t packRow(input vec8_t v);
    bits_t b;
    for (int c = 0; c < 8; c++) b[16*c +: 16] = v[c][15:0];
    return b;
  endfunction

  // R6: 2-D model, rows then columns; beat k = vertical frequency k
  task automatic pushExpected();
    int mid [8][8];
    vec8_t t, y;
    for (int r = 0; r < 8; r++) begin
      for (int c = 0; c < 8; c++) t[c] = tileIn[r][c];
      y = pass8(t);
      for (int c = 0; c < 8; c++) mid[r][c] = y[c];
    end
    for (int c = 0; c < 8; c++) begin
      for (int r = 0; r < 8; r++) t[r] = mid[r][c];
      y = pass8(t);
      for (int k = 0; k < 8; k++) mid[k][c] = y[k];
    end
    for (int k = 0; k < 8; k++) begin
      for (int c = 0; c < 8; c++) t[c] = mid[k][c];
      expQ.push_back(packRow(t));
    end
  endtask

  // driver: lastBeat is where inLast is raised (7 = correct)
  task automatic sendTile(input int lastBeat);
    vec8_t v;
    bit expErr;
    pushExpected();
    for (int b = 0; b < 8; b++) begin
      for (int c = 0; c < 8; c++) v[c] = tileIn[b][c];
      inData  = packRow(v);
      inLast  = (b == lastBeat);
      inValid = 1'b1;
      expErr  = ((b == lastBeat) != (b == 7));
      @(negedge clk);
      while (!inReady) begin
        @(posedge clk); #1;
        @(negedge clk);
      end
      @(posedge clk); #1;
      inValid = 1'b0;
      @(negedge clk);
      chk(frameErr == expErr, "R10 frameErr", bits_t'(frameErr), bits_t'(expErr));
      @(posedge clk); #1;
    end
    // R2: offer a row while busy; it must not be taken
    inValid = 1'b1;
    inData  = {8{16'h7ff1}};
  endtask

  // monitor
  initial begin
    int k;
    bit held;
    bits_t heldD;
    bits_t e;
    k = 0;
    held = 1'b0;
    heldD = '0;
    wait (rstN);
    forever begin
      @(negedge clk);
      if (held && outValid)
        chk(outData == heldD, "R9 held data", outData, heldD);
      if (outValid) begin
        chk(!inReady, "R2 no input while emitting", bits_t'(inReady), 128'd0);
      end
      if (outValid && outReady) begin
        if (expQ.size() == 0) begin
          chk(1'b0, "R6 unexpected row", outData, '0);
        end else begin
          e = expQ.pop_front();
          chk(outData == e, "R3 R4 R6 R7 coefficient row", outData, e);
          chk(outLast == (k == 7), "R8 outLast", bits_t'(outLast), bits_t'(k == 7));
        end
        k = (k + 1) % 8;
      end
      held  = outValid && !outReady;
      heldD = outData;
    end
  end

  // output backpressure
  initial begin
    forever begin
      @(posedge clk); #1;
      outReady = stallMode ? ($urandom_range(2) != 0) : 1'b1;
    end
  end

  task automatic finishRun();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finishRun();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    // R1
    chk(!outValid && !inReady && !frameErr, "R1 reset state",
        {125'd0, outValid, inReady, frameErr}, '0);
    @(negedge clk);
    chk(inReady == 1'b1, "R1 ready after reset", bits_t'(inReady), 128'd1);
    @(posedge clk); #1;

    // all zero
    for (int r = 0; r < 8; r++) for (int c = 0; c < 8; c++) tileIn[r][c] = 0;
    sendTile(7);
    // DC tile (R6)
    for (int r = 0; r < 8; r++) for (int c = 0; c < 8; c++) tileIn[r][c] = 100;
    sendTile(7);
    // single impulse at row 2, col 5 (R6 lane mapping)
    for (int r = 0; r < 8; r++) for (int c = 0; c < 8; c++) tileIn[r][c] = 0;
    tileIn[2][5] = 300;
    sendTile(7);
    // full-scale checkerboard (R7 wrap)
    for (int r = 0; r < 8; r++) for (int c = 0; c < 8; c++)
      tileIn[r][c] = ((r + c) % 2 == 0) ? 32767 : -32768;
    sendTile(7);
    // full-scale all negative (R7)
    for (int r = 0; r < 8; r++) for (int c = 0; c < 8; c++) tileIn[r][c] = -32768;
    sendTile(7);
    // R10: early inLast, framing still by count
    for (int r = 0; r < 8; r++) for (int c = 0; c < 8; c++)
      tileIn[r][c] = $urandom_range(255) - 128;
    sendTile(3);
    // random tiles with backpressure (R5 floor on negatives, R9)
    stallMode = 1'b1;
    for (int t = 0; t < 6; t++) begin
      for (int r = 0; r < 8; r++) for (int c = 0; c < 8; c++)
        tileIn[r][c] = (t % 2 == 0) ? ($urandom_range(511) - 400)
                                    : ($urandom_range(65535) - 32768);
      sendTile(7);
    end
    inValid = 1'b0;
    while (expQ.size() != 0) @(posedge clk);
    repeat (4) @(posedge clk);
    finishRun();
  end
endmodule